// File: doc/BRIEF.md
# Recursive Crosswise Significand Multiplier

This block multiplies two 24-bit unsigned operands and returns their exact 48-bit product. It is meant to be the significand datapath of a single-precision floating-point multiplier. The caller prepends the hidden leading one to each fraction and handles sign, exponent, normalization and rounding elsewhere.

The product is built bottom-up. A 3x3 base cell forms every output column by adding that column's straight and crossed bit products as soon as they exist. A parameterised level module splits each operand into a high and a low half and computes the four half-width products in parallel through recursive instances of itself. It then merges them with two ripple-carry adders. The width doubles from 3 to 6, 12 and 24. A parameter adds one output register with a valid flag, for timing closure.

Top module: `vcmul24`

## Requirements
- R1: With the output register enabled, `product` equals `a*b` taken as unsigned 48-bit arithmetic, one clock after a cycle with `in_valid` high.
- R2: A zero operand, on either side, yields a product of zero.
- R3: Two all-ones operands (0xFFFFFF) yield 0xFFFFFE000001.
- R4: Operands with a single set bit at positions i and j yield a product with only bit i+j set.
- R5: The 3x3 base cell returns the exact 6-bit product for all 64 operand pairs.
- R6: At every level with half width k, the merged result equals LL + ((HL + LH) << k) + (HH << 2k), and the final adder has no carry out.
- R7: `out_valid` is high exactly in the cycle after each cycle with `in_valid` high, so results keep the order of their operands.
- R8: While `rst_n` is low, `out_valid` and `product` are zero.
- R9: In a cycle with `in_valid` low, the registered `product` keeps its previous value and `out_valid` falls.
- R10: Significands with the hidden one set give the exact double-width product. For example, 0xC00000 times 0xC00000 gives 0x900000000000 (1.5 x 1.5 = 2.25).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands on `a` and `b` are valid this cycle |
| a | input | 24 | Unsigned multiplicand |
| b | input | 24 | Unsigned multiplier |
| out_valid | output | 1 | `product` holds a new result |
| product | output | 48 | Unsigned product |

## Verification
The datapath holds no state. A wrong column sum in a base cell or a dropped carry in a merge adder therefore appears on `product` in the very next registered result. It only appears for the operand pairs that drive that column or carry. For that reason the cell is swept exhaustively, and the top is driven with sparse single-bit patterns, dense all-ones and alternating patterns, and random pairs. Single-bit patterns isolate a wrong bit position. All-ones patterns exercise every carry chain at full length. A fault in the valid pipeline shows one cycle later as a result without a pending operand pair, or as a queue left unemptied.

// File: rtl/vcmul24.sv
module vc_cell3 (
  input  logic [2:0] a,
  input  logic [2:0] b,
  output logic [5:0] p
);
  logic c1, s2, k2, c2;
  logic [1:0] x, y;
  logic [2:0] z;

  assign p[0] = a[0] & b[0];
  assign p[1] = (a[1] & b[0]) ^ (a[0] & b[1]);
  assign c1   = (a[1] & b[0]) & (a[0] & b[1]);

  assign s2 = (a[2] & b[0]) ^ (a[1] & b[1]) ^ (a[0] & b[2]);
  assign k2 = ((a[2] & b[0]) & (a[1] & b[1])) | ((a[2] & b[0]) & (a[0] & b[2]))
            | ((a[1] & b[1]) & (a[0] & b[2]));
  assign p[2] = s2 ^ c1;
  assign c2   = s2 & c1;

  assign x = {1'b0, a[2] & b[1]} + {1'b0, a[1] & b[2]};
  assign y = {1'b0, k2} + {1'b0, c2};
  assign z = {1'b0, x} + {1'b0, y};
  assign p[5:3] = z + {a[2] & b[2], 1'b0};

  always_comb begin
    if (!$isunknown({a, b})) begin
      // R5
      cell_exact_chk: assert (p == {3'b000, a} * {3'b000, b});
    end
  end
endmodule

module vc_mul #(
  parameter int W = 24
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  generate
    if (W == 3) begin : g_base
      vc_cell3 u_cell (.a(a), .b(b), .p(p));
    end else begin : g_split
      localparam int K = W / 2;
      logic [2*K-1:0] ll, hl, lh, hh;
      logic [2*K-1:0] ms;
      logic [2*K:0]   mc;
      logic [2*K:0]   mid;
      logic [3*K-1:0] fa, fb, fs;
      logic [3*K:0]   fc;

      vc_mul #(.W(K)) u_ll (.a(a[K-1:0]), .b(b[K-1:0]), .p(ll));
      vc_mul #(.W(K)) u_hl (.a(a[W-1:K]), .b(b[K-1:0]), .p(hl));
      vc_mul #(.W(K)) u_lh (.a(a[K-1:0]), .b(b[W-1:K]), .p(lh));
      vc_mul #(.W(K)) u_hh (.a(a[W-1:K]), .b(b[W-1:K]), .p(hh));

      assign mc[0] = 1'b0;
      for (genvar i = 0; i < 2*K; i++) begin : g_mid
        assign ms[i]   = hl[i] ^ lh[i] ^ mc[i];
        assign mc[i+1] = (hl[i] & lh[i]) | (mc[i] & (hl[i] ^ lh[i]));
      end
      assign mid = {mc[2*K], ms};

      assign fa = {hh, ll[2*K-1:K]};
      assign fb = {{(K-1){1'b0}}, mid};
      assign fc[0] = 1'b0;
      for (genvar j = 0; j < 3*K; j++) begin : g_fin
        assign fs[j]   = fa[j] ^ fb[j] ^ fc[j];
        assign fc[j+1] = (fa[j] & fb[j]) | (fc[j] & (fa[j] ^ fb[j]));
      end
      assign p = {fs, ll[K-1:0]};

      always_comb begin
        if (!$isunknown({a, b})) begin
          // R6
          merge_sum_chk: assert (p == {{(2*K){1'b0}}, ll}
                                   + ({{(2*K){1'b0}}, hl} << K)
                                   + ({{(2*K){1'b0}}, lh} << K)
                                   + ({{(2*K){1'b0}}, hh} << (2*K)));
          // R6
          no_carry_out_chk: assert (fc[3*K] == 1'b0);
        end
      end
    end
  endgenerate
endmodule

module vcmul24 #(
  parameter int W       = 24,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic           out_valid,
  output logic [2*W-1:0] product
);
  logic [2*W-1:0] raw;

  vc_mul #(.W(W)) u_core (.a(a), .b(b), .p(raw));

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          product   <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) product <= raw;
        end
      end

      // R1
      prod_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> product == ({{W{1'b0}}, $past(a)} * {{W{1'b0}}, $past(b)}));
      // R7
      valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      // R7
      valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
      // R9
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(product));
    end else begin : g_comb
      assign out_valid = in_valid;
      assign product   = raw;
    end
  endgenerate
endmodule

// File: tb/sim_vcmul24.sv
module sim_vcmul24;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [23:0] a = '0, b = '0;
  logic        out_valid;
  logic [47:0] product;
  logic [2:0]  ca = '0, cb = '0;
  logic [5:0]  cp;

  int total = 0;
  int bad = 0;
  logic [47:0] exp_q[$];
  string       tag_q[$];
  logic [47:0] last_exp = '0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  vcmul24 u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
              .out_valid(out_valid), .product(product));
  vc_cell3 u_cell (.a(ca), .b(cb), .p(cp));

  task automatic check(string req, logic [47:0] act, logic [47:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic push(string req, logic [23:0] x, logic [23:0] y);
    @(negedge clk);
    a = x; b = y; in_valid = 1'b1;
    last_exp = {24'b0, x} * {24'b0, y};
    exp_q.push_back(last_exp);
    tag_q.push_back(req);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      a = 24'h5A5A5A; b = 24'hA5A5A5;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R7 spurious out_valid", 48'd1, 48'd0);
      end else begin
        logic [47:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, product, e);
      end
    end
  end

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      ca = i[2:0]; cb = i[5:3];
      #1;
      check("R5 cell", {42'b0, cp}, {42'b0, {3'b0, ca} * {3'b0, cb}});
    end

    repeat (3) @(negedge clk);
    check("R8 out_valid in reset", {47'b0, out_valid}, 48'd0);
    check("R8 product in reset", product, 48'd0);
    rst_n = 1'b1;

    push("R2 zero a", 24'd0, 24'hABCDEF);
    push("R2 zero b", 24'h123456, 24'd0);
    push("R2 zero both", 24'd0, 24'd0);
    push("R3 all ones", 24'hFFFFFF, 24'hFFFFFF);
    push("R3 ones by one", 24'hFFFFFF, 24'd1);
    push("R1 alternating", 24'hAAAAAA, 24'h555555);
    push("R1 alternating same", 24'h555555, 24'h555555);
    push("R10 hidden one 1.5x1.5", 24'hC00000, 24'hC00000);
    push("R10 hidden one max", 24'hFFFFFF, 24'h800000);
    push("R10 hidden one min", 24'h800000, 24'h800000);
    for (int i = 0; i < 24; i += 5)
      for (int j = 0; j < 24; j += 3)
        push("R4 single bit", 24'd1 << i, 24'd1 << j);
    idle(2);
    check("R7 queue drained", {47'b0, exp_q.size() != 0}, 48'd0);

    push("R9 value before gap", 24'h00F00F, 24'h0FF0F0);
    idle(1);
    @(negedge clk);
    check("R9 out_valid low in gap", {47'b0, out_valid}, 48'd0);
    check("R9 product held in gap", product, last_exp);
    idle(1);
    @(negedge clk);
    check("R9 product still held", product, last_exp);

    for (int n = 0; n < 300; n++) begin
      push("R1 random", $urandom() & 24'hFFFFFF, $urandom() & 24'hFFFFFF);
      if (n % 37 == 0) idle(1);
    end
    idle(3);
    check("R7 queue drained at end", {47'b0, exp_q.size() != 0}, 48'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    done = 1'b1;
    $finish;
  end
endmodule